// File: doc/BRIEF.md
# Farrow Fractional Rate Converter

This block lowers the sample rate of a complex (I/Q) stream by a non-integer factor. Each accepted input sample enters a four-deep delay line per lane. A phase accumulator, stepped by a programmable ratio of input samples per output sample, decides which inputs produce an output and what fractional position `mu` that output takes between two stored samples. A cubic Lagrange interpolator then forms the output in two steps. Four constant coefficient rows are evaluated as serial multiply-accumulate filters over the delay line, and their results are combined by a three-step Horner evaluation in `mu`.

The block sits in a decimating receive chain after an integer decimator and before further integer stages. There, samples arrive many clocks apart, which is what allows the serial computation. A typical ratio is about 1.228 input samples per output sample, for example 3.125 MS/s in and 2.544 MS/s out. Each row uses one multiplier per lane, and a further multiplier per lane serves the Horner steps.

Top module: `farrow_rate_conv`

## Requirements
- R1: After reset `out_vld` is 0, `out_i` and `out_q` are 0, and the ratio register holds 80503 (1.22838 in unsigned fixed point with 16 fractional bits).
- R2: No output is produced for the first three valid inputs after reset. The fourth input produces an output with `mu` = 0, whose value equals the second input sample.
- R3: After an output with phase `f` (16-bit fraction), let `s = f + r`, where `r` is the effective ratio. The next output is produced by the `floor(s/65536)`-th following valid input, with `mu = s mod 65536`.
- R4: A valid input that does not produce an output only shifts the delay line. `out_vld` stays low and `out_i`/`out_q` keep their previous values.
- R5: The output value is formed as follows. Number the stored samples by age: z0 is the newest and z3 the oldest. Row k is `ck = (sum over ages of coef(k,age)*z) >>> 14`. The coefficients, by age 0..3, are: row0 {0,0,16384,0}; row1 {-2731,16384,-8192,-5461}; row2 {0,8192,-16384,8192}; row3 {2731,-8192,8192,-2731}. The result is `h = c3`, then `h = ((h*mu)>>>16) + c2`, then `+ c1`, then `+ c0`. Every `>>>` is an arithmetic (floor) shift.
- R6: `out_vld` is a one-cycle pulse. It rises on the 9th rising edge after the edge that accepted the input producing it. Valid inputs must be spaced at least 10 cycles apart.
- R7: The final value saturates to the 18-bit signed range [-131072, 131071].
- R8: A ratio whose integer part is 0 (below 1.0) is used as exactly 1.0, so every input after the fill produces an output.
- R9: A ratio write (`ratio_we` with `ratio_in`, 3 integer bits and 16 fractional bits) takes effect at the next output scheduling decision. The spacing already scheduled is kept.
- R10: The I and Q lanes use identical arithmetic and the same `mu`, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample strobe |
| in_i | input | 18 | In-phase input, signed, 16 fractional bits |
| in_q | input | 18 | Quadrature input, signed, 16 fractional bits |
| ratio_we | input | 1 | Ratio register write strobe |
| ratio_in | input | 19 | New ratio, unsigned, 16 fractional bits |
| out_vld | output | 1 | Output sample strobe |
| out_i | output | 18 | In-phase output, signed, 16 fractional bits |
| out_q | output | 18 | Quadrature output, signed, 16 fractional bits |

## Verification
The assertions check the following on every cycle:
- No output occurs before the delay line is filled.
- Each output pulse lasts one cycle and comes exactly nine cycles after its triggering input.
- The outputs hold between pulses.
- Inputs never arrive while a computation is in flight.

The directed scenarios cover what a property cannot express compactly. These are the output schedule produced by the accumulator, the interpolated values of both lanes against an independent integer model, saturation at both rails, clamping of ratios below one, and the moment a new ratio takes effect.

// File: rtl/farrow_pkg.sv
package farrow_pkg;
  localparam int NTAP  = 4;
  localparam int NROW  = 4;
  localparam int NLANE = 2;

  // Cubic Lagrange row weights in sixths, indexed by row and sample age
  function automatic int sixths(int row, int age);
    case (row * 4 + age)
      2:  return 6;
      4:  return -1;
      5:  return 6;
      6:  return -3;
      7:  return -2;
      9:  return 3;
      10: return -6;
      11: return 3;
      12: return 1;
      13: return -3;
      14: return 3;
      15: return -1;
      default: return 0;
    endcase
  endfunction

  // Rounded fixed-point weight with fb fractional bits
  function automatic int lag_coef_q(int row, int age, int fb);
    int k;
    int s;
    k = sixths(row, age);
    s = (k < 0) ? -3 : ((k > 0) ? 3 : 0);
    return (k * (1 << fb) + s) / 6;
  endfunction
endpackage

// File: rtl/farrow_tapline.sv
module farrow_tapline #(
  parameter int DW    = 18,
  parameter int DEPTH = 4,
  localparam int SW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift,
  input  logic signed [DW-1:0] din,
  input  logic [SW-1:0]        sel,
  output logic signed [DW-1:0] tap
);
  logic signed [DW-1:0] z [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) z[k] <= '0;
    end else if (shift) begin
      z[0] <= din;
      for (int k = 1; k < DEPTH; k++) z[k] <= z[k-1];
    end
  end

  assign tap = z[sel];
endmodule

// File: rtl/farrow_row_mac.sv
module farrow_row_mac #(
  parameter int ROW = 0,
  parameter int DW  = 18,
  parameter int CW  = 16,
  parameter int CF  = 14,
  parameter int AW  = DW + CW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 clr,
  input  logic [1:0]           step,
  input  logic signed [DW-1:0] sample,
  output logic signed [AW-1:0] acc
);
  localparam int PW = DW + CW;

  logic signed [CW-1:0] coef;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_x;

  always_comb coef = CW'(farrow_pkg::lag_coef_q(ROW, int'(step), CF));
  assign prod   = sample * coef;
  assign prod_x = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (en)
      acc <= (clr ? '0 : acc) + prod_x;
  end
endmodule

// File: rtl/farrow_horner.sv
module farrow_horner #(
  parameter int DW = 18,
  parameter int AW = 36,
  parameter int CF = 14,
  parameter int MW = 16,
  parameter int HW = DW + 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 step,
  input  logic [1:0]           sel,
  input  logic [MW-1:0]        mu,
  input  logic signed [AW-1:0] acc0,
  input  logic signed [AW-1:0] acc1,
  input  logic signed [AW-1:0] acc2,
  input  logic signed [AW-1:0] acc3,
  output logic signed [HW-1:0] h
);
  localparam int KW = DW + 2;
  localparam int PW = HW + MW + 1;

  logic signed [KW-1:0] c0, c1, c2, cadd;
  logic signed [PW-1:0] prod;
  logic signed [HW-1:0] scaled;

  function automatic logic signed [KW-1:0] to_k(input logic signed [AW-1:0] a);
    return KW'(a >>> CF);
  endfunction

  function automatic logic signed [HW-1:0] ext(input logic signed [KW-1:0] v);
    return {{(HW-KW){v[KW-1]}}, v};
  endfunction

  assign prod   = h * $signed({1'b0, mu});
  assign scaled = HW'(prod >>> MW);

  always_comb begin
    case (sel)
      2'd0:    cadd = c2;
      2'd1:    cadd = c1;
      default: cadd = c0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h  <= '0;
      c0 <= '0;
      c1 <= '0;
      c2 <= '0;
    end else if (load) begin
      h  <= ext(to_k(acc3));
      c0 <= to_k(acc0);
      c1 <= to_k(acc1);
      c2 <= to_k(acc2);
    end else if (step) begin
      h <= scaled + ext(cadd);
    end
  end
endmodule

// File: rtl/farrow_phase_acc.sv
module farrow_phase_acc #(
  parameter int MW        = 16,
  parameter int RI        = 3,
  parameter int RATIO_RST = 80503,
  localparam int RTW      = MW + RI
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_vld,
  input  logic           ratio_we,
  input  logic [RTW-1:0] ratio_in,
  output logic           due,
  output logic [MW-1:0]  mu
);
  localparam int NW = RI + 1;

  logic [RTW-1:0] ratio_q, eff;
  logic [MW-1:0]  frac_q;
  logic [NW-1:0]  need_q;
  logic [RTW:0]   sum;

  // Ratios below one are run at exactly one
  assign eff = (ratio_q[RTW-1:MW] == '0) ? (RTW'(1) << MW) : ratio_q;
  assign sum = {1'b0, eff} + {{(RI+1){1'b0}}, frac_q};
  assign due = in_vld && (need_q == NW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= RTW'(RATIO_RST);
      frac_q  <= '0;
      need_q  <= NW'(farrow_pkg::NTAP);
      mu      <= '0;
    end else begin
      if (ratio_we) ratio_q <= ratio_in;
      if (in_vld) begin
        if (due) begin
          mu     <= frac_q;
          frac_q <= sum[MW-1:0];
          need_q <= sum[RTW:MW];
        end else begin
          need_q <= need_q - NW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/farrow_rate_conv.sv
module farrow_rate_conv #(
  parameter int DATA_W    = 18,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int MU_W      = 16,
  parameter int RATIO_INT = 3,
  parameter int RATIO_RST = 80503
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_vld,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic                     ratio_we,
  input  logic [MU_W+RATIO_INT-1:0] ratio_in,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);
  import farrow_pkg::*;

  localparam int ACC_W  = DATA_W + COEF_W + 2;
  localparam int H_W    = DATA_W + 4;
  localparam int PH_W   = 4;
  localparam logic [PH_W-1:0] PH_MAC_END = PH_W'(NTAP - 1);
  localparam logic [PH_W-1:0] PH_LOAD    = PH_W'(NTAP);
  localparam logic [PH_W-1:0] PH_H_FIRST = PH_W'(NTAP + 1);
  localparam logic [PH_W-1:0] PH_H_LAST  = PH_W'(NTAP + 3);
  localparam logic [PH_W-1:0] PH_OUT     = PH_W'(NTAP + 4);
  localparam logic signed [DATA_W-1:0] SAT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] SAT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic            due;
  logic [MU_W-1:0] mu;
  logic            busy;
  logic [PH_W-1:0] ph;
  logic            mac_en, mac_clr, h_load, h_step, out_en;
  logic [1:0]      h_sel;

  farrow_phase_acc #(
    .MW(MU_W), .RI(RATIO_INT), .RATIO_RST(RATIO_RST)
  ) u_phase (
    .clk(clk), .rst(rst), .in_vld(in_vld), .ratio_we(ratio_we),
    .ratio_in(ratio_in), .due(due), .mu(mu)
  );

  // Serial schedule: 4 tap cycles, 1 load, 3 Horner steps, 1 output
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (due) begin
      busy <= 1'b1;
      ph   <= '0;
    end else if (busy) begin
      if (ph == PH_OUT) busy <= 1'b0;
      ph <= ph + PH_W'(1);
    end
  end

  assign mac_en  = busy && (ph <= PH_MAC_END);
  assign mac_clr = (ph == '0);
  assign h_load  = busy && (ph == PH_LOAD);
  assign h_step  = busy && (ph >= PH_H_FIRST) && (ph <= PH_H_LAST);
  assign h_sel   = ph[1:0] - 2'd1;
  assign out_en  = busy && (ph == PH_OUT);

  logic signed [DATA_W-1:0] lane_in [NLANE];
  logic signed [H_W-1:0]    lane_h  [NLANE];

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar L = 0; L < NLANE; L++) begin : g_lane
    logic signed [DATA_W-1:0] tap;
    logic signed [ACC_W-1:0]  racc [NROW];

    farrow_tapline #(.DW(DATA_W), .DEPTH(NTAP)) u_line (
      .clk(clk), .rst(rst), .shift(in_vld), .din(lane_in[L]),
      .sel(ph[1:0]), .tap(tap)
    );

    for (genvar R = 0; R < NROW; R++) begin : g_row
      farrow_row_mac #(
        .ROW(R), .DW(DATA_W), .CW(COEF_W), .CF(COEF_FRAC), .AW(ACC_W)
      ) u_mac (
        .clk(clk), .rst(rst), .en(mac_en), .clr(mac_clr),
        .step(ph[1:0]), .sample(tap), .acc(racc[R])
      );
    end

    farrow_horner #(
      .DW(DATA_W), .AW(ACC_W), .CF(COEF_FRAC), .MW(MU_W), .HW(H_W)
    ) u_horner (
      .clk(clk), .rst(rst), .load(h_load), .step(h_step), .sel(h_sel),
      .mu(mu), .acc0(racc[0]), .acc1(racc[1]), .acc2(racc[2]),
      .acc3(racc[3]), .h(lane_h[L])
    );
  end

  function automatic logic signed [DATA_W-1:0] sat(input logic signed [H_W-1:0] v);
    if (v[H_W-1:DATA_W-1] == '0 || v[H_W-1:DATA_W-1] == '1)
      return v[DATA_W-1:0];
    else
      return v[H_W-1] ? SAT_MIN : SAT_MAX;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_i   <= '0;
      out_q   <= '0;
    end else begin
      out_vld <= out_en;
      if (out_en) begin
        out_i <= sat(lane_h[0]);
        out_q <= sat(lane_h[1]);
      end
    end
  end
endmodule

// File: rtl/farrow_rate_conv_chk.sv
module farrow_rate_conv_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic          due,
  input logic          busy,
  input logic          out_vld,
  input logic [DW-1:0] out_i,
  input logic [DW-1:0] out_q
);
  logic [2:0] fill_cnt;
  logic [9:0] due_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt <= '0;
      due_sh   <= '0;
    end else begin
      if (in_vld && fill_cnt < 3'd4) fill_cnt <= fill_cnt + 3'd1;
      due_sh <= {due_sh[8:0], due};
    end
  end

  // R2: nothing comes out before four inputs were taken
  p_fill_r2: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt < 3'd4) |-> !out_vld);

  // R2: an output is only scheduled on the fourth input or later
  p_due_fill_r2: assert property (@(posedge clk) disable iff (rst)
    due |-> (fill_cnt >= 3'd3));

  // R6: single-cycle strobe
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  // R6: fixed nine-edge latency from the scheduling input
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    out_vld == due_sh[9]);

  // R6: inputs are not accepted mid-computation
  p_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> !busy);

  // R4: outputs hold between strobes
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind farrow_rate_conv farrow_rate_conv_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .due(due), .busy(busy),
  .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
);

// File: tb/farrow_rate_conv_test.sv
module farrow_rate_conv_test;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_vld = 1'b0;
  logic signed [17:0] in_i = '0;
  logic signed [17:0] in_q = '0;
  logic               ratio_we = 1'b0;
  logic [18:0]        ratio_in = '0;
  logic               out_vld;
  logic signed [17:0] out_i, out_q;

  always #2 clk = ~clk;

  farrow_rate_conv uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .ratio_we(ratio_we), .ratio_in(ratio_in), .out_vld(out_vld),
    .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state derived from the requirements
  int m_need, m_frac, m_ratio;
  int hi [4];
  int hq [4];
  int n_out, n_sat, last_i, last_q;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic longint cf(int row, int age);
    case (row * 4 + age)
      2:  return 16384;
      4:  return -2731;
      5:  return 16384;
      6:  return -8192;
      7:  return -5461;
      9:  return 8192;
      10: return -16384;
      11: return 8192;
      12: return 2731;
      13: return -8192;
      14: return 8192;
      15: return -2731;
      default: return 0;
    endcase
  endfunction

  function automatic int interp(int z0, int z1, int z2, int z3, int mu);
    longint z [4];
    longint c [4];
    longint h;
    z[0] = z0; z[1] = z1; z[2] = z2; z[3] = z3;
    for (int r = 0; r < 4; r++) begin
      longint a = 0;
      for (int g = 0; g < 4; g++) a += cf(r, g) * z[g];
      c[r] = a >>> 14;
    end
    h = c[3];
    h = ((h * longint'(mu)) >>> 16) + c[2];
    h = ((h * longint'(mu)) >>> 16) + c[1];
    h = ((h * longint'(mu)) >>> 16) + c[0];
    if (h > 131071) h = 131071;
    if (h < -131072) h = -131072;
    return int'(h);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_need = 4; m_frac = 0; m_ratio = 80503;
    for (int k = 0; k < 4; k++) begin hi[k] = 0; hq[k] = 0; end
    n_out = 0; n_sat = 0; last_i = 0; last_q = 0;
  endtask

  task automatic wr_ratio(int v);
    @(negedge clk);
    ratio_we = 1'b1;
    ratio_in = 19'(v);
    @(negedge clk);
    ratio_we = 1'b0;
    m_ratio = v;
  endtask

  task automatic push(int xi, int xq, string tag);
    bit exp_v;
    int ei, eq, eff, sum, seen, lat, gi, gq, pi, pq;
    for (int k = 3; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
    hi[0] = xi; hq[0] = xq;
    exp_v = 0; ei = 0; eq = 0;
    if (m_need == 1) begin
      exp_v = 1;
      ei = interp(hi[0], hi[1], hi[2], hi[3], m_frac);
      eq = interp(hq[0], hq[1], hq[2], hq[3], m_frac);
      eff = (m_ratio < 65536) ? 65536 : m_ratio;
      sum = m_frac + eff;
      m_need = sum >> 16;
      m_frac = sum & 65535;
    end else begin
      m_need--;
    end
    pi = out_i; pq = out_q;
    @(negedge clk);
    in_vld = 1'b1; in_i = 18'(xi); in_q = 18'(xq);
    @(posedge clk);
    @(negedge clk);
    in_vld = 1'b0;
    seen = 0; lat = 0; gi = 0; gq = 0;
    for (int c = 1; c <= 11; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (out_vld) begin
        seen++; lat = c; gi = out_i; gq = out_q;
      end
    end
    if (exp_v) begin
      check(seen == 1, "R3", "output scheduled", seen, 1);
      if (seen == 1) begin
        check(lat == 9, "R6", "latency", lat, 9);
        check(gi == ei, tag, "I value", gi, ei);
        check(gq == eq, "R10", "Q value", gq, eq);
        n_out++; last_i = gi; last_q = gq;
        if (gi == 131071 || gi == -131072 || gq == 131071 || gq == -131072) n_sat++;
      end
    end else begin
      check(seen == 0, "R4", "no output strobe", seen, 0);
      check(out_i == 18'(pi) && out_q == 18'(pq), "R4", "output held", out_i, pi);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(out_vld == 1'b0, "R1", "out_vld after reset", out_vld, 0);
    check(out_i == 0, "R1", "out_i after reset", out_i, 0);
    check(out_q == 0, "R1", "out_q after reset", out_q, 0);
  endtask

  task automatic t_fill();
    do_reset();
    for (int k = 1; k <= 4; k++) push(1000 * k, -700 * k, "R2");
    check(n_out == 1, "R2", "outputs during fill", n_out, 1);
    check(last_i == 2000, "R2", "first output equals second input", last_i, 2000);
  endtask

  task automatic t_stream();
    do_reset();
    for (int k = 0; k < 40; k++)
      push(((k * 7919) % 60000) - 30000, 45000 - ((k * 104729) % 90000), "R5");
    check(n_out >= 28 && n_out <= 31, "R3", "outputs in 40 inputs", n_out, 30);
  endtask

  task automatic t_clamp();
    do_reset();
    wr_ratio(32768);
    for (int k = 0; k < 12; k++) push(3000 * k - 9000, 500 * k, "R8");
    check(n_out == 9, "R8", "one output per input below unity", n_out, 9);
  endtask

  task automatic t_sat();
    do_reset();
    wr_ratio(98304);
    for (int k = 1; k <= 24; k++) begin
      int v = ((k % 4) == 1 || (k % 4) == 2) ? 131071 : -131072;
      push(v, (v == 131071) ? -131072 : 131071, "R7");
    end
    check(n_sat > 0, "R7", "rail reached", n_sat, 1);
  endtask

  task automatic t_change();
    int first;
    do_reset();
    wr_ratio(131072);
    for (int k = 1; k <= 9; k++) push(k * 1500, -k * 900, "R9");
    first = n_out;
    check(first == 3, "R9", "outputs at ratio 2.0", first, 3);
    wr_ratio(196608);
    for (int k = 10; k <= 18; k++) push(k * 1500, -k * 900, "R9");
    check(n_out - first == 3, "R9", "outputs after switching to 3.0", n_out - first, 3);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_stream();
    t_clamp();
    t_sat();
    t_change();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule